// File: doc/BRIEF.md
# Byte Link Port

A small peripheral that lets a processor move single bytes over a point-to-point link using ordinary loads and stores. It sits on a byte-wide bus. Four fixed addresses in that bus map hold an interrupt-enable register, a status register, an outgoing data register and an incoming data register. Reads are combinational from the address. Writes take effect on the rising clock edge.

Outgoing traffic works as follows. Software places a byte in the outgoing register and then sets the send bit of the status register. The port offers the byte on a valid/ready link and holds it there until the far side accepts. When the far side accepts, hardware drops the send bit.

Incoming traffic works the other way round. The link strobes a byte in, and the port latches it. Hardware raises the full bit, and software lowers that bit once it has consumed the byte. A byte that lands on top of unread data sets a sticky overrun bit. One level-sensitive interrupt line reports, under two enable bits, either an idle transmitter or waiting receive data.

Top module: `byte_link_port`

## Requirements
- R1: After reset, the status register reads 0, the enable register reads 0, `txValid` is low and `irq` is low.
- R2: Writing a byte to address 98 while the send bit (status bit 0, address 97) is 0 stores it. Writing status with bit 0 set then raises the send bit, and `txValid` goes high with `txData` equal to the stored byte.
- R3: While the send bit is 1, `txValid` stays high and `txData` stays stable until `txReady` is sampled high. After that edge, `txValid` is low and status bit 0 reads 0.
- R4: A write to address 98 while the send bit is 1 has no effect on `txData` or on the byte later sent.
- R5: A cycle with `rxValid` high latches `rxData` into the receive register, which reads back at address 99. It also sets status bit 1 (full).
- R6: A status write with bit 1 at 0 clears the full bit. A status write with bit 1 at 1 leaves it unchanged. Writing 0 to bit 0 never cancels a send in progress.
- R7: A byte that arrives while the full bit is 1 overwrites the receive register and sets status bit 2 (overrun). The overrun bit stays set until a status write with bit 2 at 0.
- R8: Status bits 7..3 always read 0. The enable register at address 96 holds bit 0 (idle-transmitter interrupt enable) and bit 1 (receive interrupt enable). Its bits 7..2 read 0.
- R9: `irq` equals (enable bit 0 AND NOT send bit) OR (enable bit 1 AND full bit), driven from the registered state.
- R10: If a byte arrives in the same cycle as a status write that clears the full bit, the full bit ends set and no overrun is recorded.
- R11: A read of any address other than 96..99 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Bus byte address |
| busWrEn | input | 1 | Bus write strobe |
| busWrData | input | 8 | Bus write data |
| busRdData | output | 8 | Bus read data for `busAddr` |
| txValid | output | 1 | Outgoing byte offered |
| txReady | input | 1 | Far side accepts the outgoing byte |
| txData | output | 8 | Outgoing byte |
| rxValid | input | 1 | Incoming byte strobe |
| rxData | input | 8 | Incoming byte |
| irq | output | 1 | Level interrupt |

## Verification
The bench sweeps every byte value through both directions. This exposes a stuck or swapped data bit, and a transmitter that drops the byte before `txReady` arrives. It writes the outgoing register in the middle of a send. A port that accepted that write would change the byte on the link.

The bench also stacks arrivals to provoke an overrun, and it clears the full bit in the same cycle a byte lands. A design with the wrong priority there would lose the new byte's flag or log a false overrun.

Finally, the bench walks all enable and state combinations for `irq`, and it reads every unmapped address. A loose address decode would alias a register into those reads.

// File: rtl/blp_pkg.sv
package blp_pkg;
  // strobes from the control section to the data registers
  typedef struct packed {
    logic ldTx;
    logic ldRx;
  } blpStrobe_t;
endpackage

// File: rtl/blp_ctrl.sv
module blp_ctrl
  import blp_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int CTRL_ADDR = 96,
  parameter int STAT_ADDR = 97,
  parameter int TX_ADDR   = 98
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              txReady,
  input  logic              rxValid,
  output blpStrobe_t        strobe,
  output logic              busy,
  output logic              rxFull,
  output logic              ovr,
  output logic [1:0]        irqEn,
  output logic              irq
);
  localparam int EN_W = 2;

  logic wrStat, wrTx, wrCtrl, clrFull;

  assign wrStat  = busWrEn && (busAddr == ADDR_W'(STAT_ADDR));
  assign wrTx    = busWrEn && (busAddr == ADDR_W'(TX_ADDR));
  assign wrCtrl  = busWrEn && (busAddr == ADDR_W'(CTRL_ADDR));
  assign clrFull = wrStat && !busWrData[1];

  always_comb begin
    strobe.ldTx = wrTx && !busy;
    strobe.ldRx = rxValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      rxFull <= 1'b0;
      ovr    <= 1'b0;
      irqEn  <= '0;
    end else begin
      if (busy) begin
        if (txReady) busy <= 1'b0;
      end else if (wrStat && busWrData[0]) begin
        busy <= 1'b1;
      end

      if (rxValid)      rxFull <= 1'b1;
      else if (clrFull) rxFull <= 1'b0;

      if (rxValid && rxFull && !clrFull) ovr <= 1'b1;
      else if (wrStat && !busWrData[2])  ovr <= 1'b0;

      if (wrCtrl) irqEn <= busWrData[EN_W-1:0];
    end
  end

  assign irq = (irqEn[0] && !busy) || (irqEn[1] && rxFull);
endmodule

// File: rtl/blp_dp.sv
module blp_dp
  import blp_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int CTRL_ADDR = 96,
  parameter int STAT_ADDR = 97,
  parameter int TX_ADDR   = 98,
  parameter int RX_ADDR   = 99
) (
  input  logic              clk,
  input  logic              rstN,
  input  blpStrobe_t        strobe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic [DATA_W-1:0] rxData,
  input  logic              busy,
  input  logic              rxFull,
  input  logic              ovr,
  input  logic [1:0]        irqEn,
  output logic [DATA_W-1:0] txData,
  output logic [DATA_W-1:0] busRdData
);
  localparam int STAT_PAD = DATA_W - 3;
  localparam int EN_PAD   = DATA_W - 2;

  logic [DATA_W-1:0] txReg, rxReg, statByte, ctrlByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txReg <= '0;
      rxReg <= '0;
    end else begin
      if (strobe.ldTx) txReg <= busWrData;
      if (strobe.ldRx) rxReg <= rxData;
    end
  end

  assign statByte = {{STAT_PAD{1'b0}}, ovr, rxFull, busy};
  assign ctrlByte = {{EN_PAD{1'b0}}, irqEn};
  assign txData   = txReg;

  always_comb begin
    if (busAddr == ADDR_W'(CTRL_ADDR))      busRdData = ctrlByte;
    else if (busAddr == ADDR_W'(STAT_ADDR)) busRdData = statByte;
    else if (busAddr == ADDR_W'(TX_ADDR))   busRdData = txReg;
    else if (busAddr == ADDR_W'(RX_ADDR))   busRdData = rxReg;
    else                                    busRdData = '0;
  end
endmodule

// File: rtl/byte_link_port.sv
module byte_link_port
  import blp_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int CTRL_ADDR = 96,
  parameter int STAT_ADDR = 97,
  parameter int TX_ADDR   = 98,
  parameter int RX_ADDR   = 99
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              txValid,
  input  logic              txReady,
  output logic [DATA_W-1:0] txData,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxData,
  output logic              irq
);
  blpStrobe_t strobeW;
  logic       busyW, rxFullW, ovrW;
  logic [1:0] irqEnW;

  blp_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR),
    .STAT_ADDR(STAT_ADDR), .TX_ADDR(TX_ADDR)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .txReady(txReady), .rxValid(rxValid),
    .strobe(strobeW), .busy(busyW), .rxFull(rxFullW), .ovr(ovrW),
    .irqEn(irqEnW), .irq(irq)
  );

  blp_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR),
    .STAT_ADDR(STAT_ADDR), .TX_ADDR(TX_ADDR), .RX_ADDR(RX_ADDR)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobeW), .busAddr(busAddr),
    .busWrData(busWrData), .rxData(rxData), .busy(busyW),
    .rxFull(rxFullW), .ovr(ovrW), .irqEn(irqEnW), .txData(txData),
    .busRdData(busRdData)
  );

  assign txValid = busyW;
endmodule

// File: rtl/blp_checker.sv
module blp_checker #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int STAT_ADDR = 97,
  parameter int TX_ADDR   = 98
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic [DATA_W-1:0] busWrData,
  input logic              txValid,
  input logic              txReady,
  input logic [DATA_W-1:0] txData,
  input logic              rxValid,
  input logic              rxFull,
  input logic              ovr
);
  logic wrStat, wrTx;
  assign wrStat = busWrEn && (busAddr == ADDR_W'(STAT_ADDR));
  assign wrTx   = busWrEn && (busAddr == ADDR_W'(TX_ADDR));

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    txValid && !txReady |=> txValid && $stable(txData)); // R3
  AST_TX_DROP: assert property (@(posedge clk) disable iff (!rstN)
    txValid && txReady |=> !txValid); // R3
  AST_TX_WR_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    txValid && wrTx |=> $stable(txData)); // R4
  AST_RX_FULL_SET: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> rxFull); // R5
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    ovr && !(wrStat && !busWrData[2]) |=> ovr); // R7
  AST_OVR_ON_STACK: assert property (@(posedge clk) disable iff (!rstN)
    rxValid && rxFull && !(wrStat && !busWrData[1]) |=> ovr); // R7
  AST_NO_FALSE_OVR: assert property (@(posedge clk) disable iff (!rstN)
    !ovr && rxValid && wrStat && !busWrData[1] && busWrData[2] |=> !ovr); // R10
endmodule

bind byte_link_port blp_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_ADDR(STAT_ADDR), .TX_ADDR(TX_ADDR)
) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
  .busWrData(busWrData), .txValid(txValid), .txReady(txReady),
  .txData(txData), .rxValid(rxValid), .rxFull(rxFullW), .ovr(ovrW)
);

// File: tb/byte_link_port_bench.sv
module byte_link_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_CTRL = 8'd96;
  localparam logic [7:0] A_STAT = 8'd97;
  localparam logic [7:0] A_TX   = 8'd98;
  localparam logic [7:0] A_RX   = 8'd99;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] busAddr = '0;
  logic       busWrEn = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic       txValid;
  logic       txReady = 1'b0;
  logic [7:0] txData;
  logic       rxValid = 1'b0;
  logic [7:0] rxData = '0;
  logic       irq;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  byte_link_port u_byte_link_port (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .txValid(txValid),
    .txReady(txReady), .txData(txData), .rxValid(rxValid),
    .rxData(rxData), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // all tasks are entered just after a falling edge
  task automatic busWrite(input logic [7:0] a, input logic [7:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(posedge clk); @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [7:0] v);
    busAddr = a; #1; v = busRdData;
  endtask

  task automatic rxPulse(input logic [7:0] d);
    rxValid = 1'b1; rxData = d;
    @(posedge clk); @(negedge clk);
    rxValid = 1'b0;
  endtask

  task automatic txAccept();
    txReady = 1'b1;
    @(posedge clk); @(negedge clk);
    txReady = 1'b0;
  endtask

  task automatic expectReg(input logic [7:0] a, input logic [7:0] e, input string tag);
    logic [7:0] v;
    busRead(a, v);
    chk(v == e, tag, v, e);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    expectReg(A_STAT, 8'h00, "R1 status");
    expectReg(A_CTRL, 8'h00, "R1 enables");
    chk(!txValid, "R1 txValid", txValid, 0);
    chk(!irq, "R1 irq", irq, 0);

    // R11 unmapped addresses read zero
    for (int a = 0; a < 256; a++) begin
      if (a < 96 || a > 99) begin
        busRead(8'(a), v);
        chk(v == 8'h00, "R11 unmapped", v, 0);
      end
    end

    // R2 R3 R4 transmit sweep over every byte
    for (int b = 0; b < 256; b++) begin
      busWrite(A_TX, 8'(b));
      chk(!txValid, "R2 idle before start", txValid, 0);
      busWrite(A_STAT, 8'h01);
      chk(txValid && txData == 8'(b), "R2 offered byte", txData, b);
      expectReg(A_STAT, 8'h01, "R2 send bit");
      busWrite(A_TX, ~8'(b));
      chk(txData == 8'(b), "R4 write while busy", txData, b);
      busWrite(A_STAT, 8'h00);
      chk(txValid && txData == 8'(b), "R6 R3 hold without ready", txData, b);
      txAccept();
      chk(!txValid, "R3 valid drops", txValid, 0);
      expectReg(A_STAT, 8'h00, "R3 send bit cleared");
    end

    // R5 R6 R7 receive sweep
    for (int b = 0; b < 256; b++) begin
      rxPulse(8'(b));
      expectReg(A_RX, 8'(b), "R5 rx byte");
      expectReg(A_STAT, 8'h02, "R5 full bit");
      busWrite(A_STAT, 8'h06);
      expectReg(A_STAT, 8'h02, "R6 write one keeps full");
      rxPulse(8'(b) ^ 8'h5A);
      expectReg(A_RX, 8'(b) ^ 8'h5A, "R7 overwrite");
      expectReg(A_STAT, 8'h06, "R7 overrun set");
      busWrite(A_STAT, 8'h04);
      expectReg(A_STAT, 8'h04, "R6 R7 clear full keep overrun");
      busWrite(A_STAT, 8'h00);
      expectReg(A_STAT, 8'h00, "R7 overrun cleared");
    end

    // R10 arrival in the same cycle as a full-bit clear
    rxPulse(8'h11);
    busAddr = A_STAT; busWrData = 8'h04; busWrEn = 1'b1;
    rxValid = 1'b1; rxData = 8'hC3;
    @(posedge clk); @(negedge clk);
    busWrEn = 1'b0; rxValid = 1'b0;
    expectReg(A_STAT, 8'h02, "R10 full kept no overrun");
    expectReg(A_RX, 8'hC3, "R10 new byte");
    busWrite(A_STAT, 8'h00);

    // R8 enable register and high status bits
    busWrite(A_CTRL, 8'hFF);
    expectReg(A_CTRL, 8'h03, "R8 enable width");
    busWrite(A_STAT, 8'hF8);
    expectReg(A_STAT, 8'h00, "R8 status upper zero");

    // R9 interrupt over all enable and state combinations
    for (int en = 0; en < 4; en++) begin
      for (int bz = 0; bz < 2; bz++) begin
        for (int fl = 0; fl < 2; fl++) begin
          busWrite(A_CTRL, 8'(en));
          if (bz == 1) begin
            busWrite(A_TX, 8'h3C);
            busWrite(A_STAT, 8'h01);
          end
          if (fl == 1) rxPulse(8'h77);
          chk(irq == (((en & 1) != 0 && bz == 0) || ((en & 2) != 0 && fl == 1)),
              "R9 irq", irq, (((en & 1) != 0 && bz == 0) || ((en & 2) != 0 && fl == 1)));
          if (bz == 1) txAccept();
          busWrite(A_STAT, 8'h00);
        end
      end
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule